// File: doc/BRIEF.md
# Five-Level Current-Source Inverter Gate Sequencer

This block drives the eight reverse-blocking switches of a single-phase current-source inverter built around two DC-link inductors and a polarity-reversing bridge. Each sample period it receives a signed output-level request from a modulator: full negative, half negative, zero, half positive or full positive source current. Alongside the request come signed digitized samples of load voltage, both inductor currents and the source current. It captures all of these on a sample strobe and turns them into a set of gate commands.

The half-current levels can be produced by two redundant switch states, and the two states push the inductor-current difference in opposite directions. The block picks one of them from the product of three signs: output current, load voltage and a hysteretic inductor-imbalance sign. In single-inductor mode the imbalance is taken between the remaining inductor and half the source current. The bridge polarity is latched per half-cycle, so steps between zero and a half level do not toggle the bridge. A per-gate turn-off extension makes an outgoing switch overlap the incoming one, so the inductor current is never left without a path.

Top module: `csi_gate_seq`

## Requirements
- R1: While reset is high and after it is released, until the first strobe, the gate vector is the zero state with positive bridge: 0x3A. Gate bit positions are: 0 leg-A feed, 1 leg-A bypass, 2 leg-B feed, 3 leg-B bypass, 4 positive-bridge high, 5 positive-bridge low, 6 negative-bridge high, 7 negative-bridge low.
- R2: Inputs are taken only on a clock edge with `smp_stb` high. Newly asserted gates appear one clock after that edge. Without a strobe, input changes have no effect on the gates.
- R3: A request of +2 or more gives 0x35 (both feeds plus positive bridge). A request of -2 or less (including -3 and -4) gives 0xC5 (both feeds plus negative bridge).
- R4: A zero request turns on both bypass switches and no feed switch. The bridge keeps the latched polarity, giving 0x3A for positive and 0xCA for negative.
- R5: The bridge polarity latch becomes positive on any positive request and negative on any negative request. A zero request leaves it unchanged. Reset polarity is positive.
- R6: At a half level (+1 or -1), the bridge follows the request sign. Let s be the product of the request sign, the load-voltage sign and the imbalance sign, where a sign is +1 for a value of zero or more. If s = +1, leg-A feed and leg-B bypass are on. If s = -1, leg-B feed and leg-A bypass are on.
- R7: In dual mode (`single_ind` = 0) the imbalance difference is i1 - i2. In single mode it is i1 - (isrc arithmetically shifted right by one, rounding toward minus infinity), and i2 is ignored.
- R8: On each strobe, the imbalance sign becomes +1 when the difference is at least `hyst_band` and -1 when the difference is below -`hyst_band`. Otherwise it keeps its previous value. It resets to +1.
- R9: A gate turning on changes one clock after its cause. A gate turning off stays on for `OFF_DLY` extra clocks.
- R10: At every cycle each leg has its feed or its bypass switch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe |
| lvl_req | input | 3 | Signed level request |
| single_ind | input | 1 | 1 = single-inductor mode |
| v_load | input | DW | Signed load-voltage sample |
| i_ind1 | input | DW | Signed inductor-1 current sample |
| i_ind2 | input | DW | Signed inductor-2 current sample |
| i_src | input | DW | Signed source-current sample |
| hyst_band | input | DW-1 | Unsigned hysteresis half-width |
| gate_o | output | 8 | Gate commands, bit map in R1 |

## Verification
The bench builds the block with an 8-bit sample width and a three-clock turn-off extension. With these values, the gate vector after each strobe can be checked both during the overlap window and once it has settled. The sweep covers every 3-bit request, including the out-of-range codes, in both inductor modes. It combines those requests with load voltages of both signs and imbalance differences on either side of zero. Directed sequences then probe the edges of the hysteresis band, the floor rounding of the halved source current, and the polarity held through zero requests.

// File: rtl/csi_pkg.sv
package csi_pkg;

    typedef logic signed [2:0] lvl_t;

    typedef struct packed {
        logic n_lo;
        logic n_hi;
        logic p_lo;
        logic p_hi;
        logic b_byp;
        logic b_feed;
        logic a_byp;
        logic a_feed;
    } gate_t;

    localparam int NGATE = 8;
    localparam gate_t ZERO_POS = 8'h3A;

    function automatic gate_t lvl_gates(lvl_t l, logic pol, logic vpos, logic imbpos);
        gate_t g;
        logic  io_pos;
        logic  sel;
        g      = '0;
        io_pos = (l > 0);
        sel    = ~((~io_pos) ^ (~vpos) ^ (~imbpos));
        if (l >= 3'sd2) begin
            g.a_feed = 1'b1; g.b_feed = 1'b1; g.p_hi = 1'b1; g.p_lo = 1'b1;
        end else if (l <= -3'sd2) begin
            g.a_feed = 1'b1; g.b_feed = 1'b1; g.n_hi = 1'b1; g.n_lo = 1'b1;
        end else if (l == 3'sd0) begin
            g.a_byp = 1'b1; g.b_byp = 1'b1;
            g.p_hi  = pol;  g.p_lo  = pol;
            g.n_hi  = ~pol; g.n_lo  = ~pol;
        end else begin
            g.a_feed = sel;  g.b_byp = sel;
            g.b_feed = ~sel; g.a_byp = ~sel;
            g.p_hi   = io_pos;  g.p_lo = io_pos;
            g.n_hi   = ~io_pos; g.n_lo = ~io_pos;
        end
        return g;
    endfunction

endpackage

// File: rtl/csi_imb_hyst.sv
module csi_imb_hyst #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic                 single,
    input  logic signed [DW-1:0] i1,
    input  logic signed [DW-1:0] i2,
    input  logic signed [DW-1:0] isrc,
    input  logic        [DW-2:0] band,
    output logic                 pos_q
);
    logic signed [DW:0] ref_s;
    logic signed [DW:0] diff;
    logic signed [DW:0] bnd;

    always_comb begin
        if (single)
            ref_s = $signed({isrc[DW-1], isrc}) >>> 1;
        else
            ref_s = $signed({i2[DW-1], i2});
        diff = $signed({i1[DW-1], i1}) - ref_s;
        bnd  = $signed({2'b00, band});
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= 1'b1;
        else if (stb) begin
            if (diff >= bnd)
                pos_q <= 1'b1;
            else if (diff < -bnd)
                pos_q <= 1'b0;
        end
    end

    // R8: inside the band the sign is held
    p_band_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (stb && (diff < bnd) && (diff >= -bnd)) |=> $stable(pos_q));

endmodule

// File: rtl/csi_lvl_dec.sv
module csi_lvl_dec #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  csi_pkg::lvl_t        lvl,
    input  logic signed [DW-1:0] v_load,
    input  logic                 imb_pos,
    output csi_pkg::gate_t       ideal
);
    import csi_pkg::*;

    lvl_t lvl_q;
    logic vpos_q;
    logic pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            vpos_q <= 1'b1;
            pol_q  <= 1'b1;
        end else if (stb) begin
            lvl_q  <= lvl;
            vpos_q <= ~v_load[DW-1];
            if (lvl > 0)
                pol_q <= 1'b1;
            else if (lvl < 0)
                pol_q <= 1'b0;
        end
    end

    always_comb ideal = lvl_gates(lvl_q, pol_q, vpos_q, imb_pos);

    // R5: a zero request never moves the bridge polarity
    p_pol_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (stb && lvl == 3'sd0) |=> $stable(pol_q));

endmodule

// File: rtl/csi_offdly.sv
module csi_offdly #(
    parameter int unsigned DLY     = 50,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = (DLY < 1) ? 1 : $clog2(DLY + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= RST_VAL;
            cnt  <= '0;
        end else if (din) begin
            dout <= 1'b1;
            cnt  <= CW'(DLY);
        end else if (cnt != '0) begin
            dout <= 1'b1;
            cnt  <= cnt - 1'b1;
        end else begin
            dout <= 1'b0;
        end
    end

    // R9: turn-on passes after one clock
    p_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(din) |=> dout);

    generate
        if (DLY > 0) begin : g_ext
            // R9: turn-off is extended
            p_late_fall_r9: assert property (@(posedge clk) disable iff (rst)
                $fell(din) |=> dout);
        end
    endgenerate

endmodule

// File: rtl/csi_gate_seq.sv
module csi_gate_seq #(
    parameter int          DW      = 16,
    parameter int unsigned OFF_DLY = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_stb,
    input  logic signed [2:0]    lvl_req,
    input  logic                 single_ind,
    input  logic signed [DW-1:0] v_load,
    input  logic signed [DW-1:0] i_ind1,
    input  logic signed [DW-1:0] i_ind2,
    input  logic signed [DW-1:0] i_src,
    input  logic        [DW-2:0] hyst_band,
    output logic        [7:0]    gate_o
);
    import csi_pkg::*;

    logic  imb_pos;
    gate_t ideal;
    logic [NGATE-1:0] ideal_v;
    logic [NGATE-1:0] out_v;

    csi_imb_hyst #(.DW(DW)) u_imb (
        .clk(clk), .rst(rst), .stb(smp_stb), .single(single_ind),
        .i1(i_ind1), .i2(i_ind2), .isrc(i_src), .band(hyst_band),
        .pos_q(imb_pos)
    );

    csi_lvl_dec #(.DW(DW)) u_dec (
        .clk(clk), .rst(rst), .stb(smp_stb), .lvl(lvl_req),
        .v_load(v_load), .imb_pos(imb_pos), .ideal(ideal)
    );

    assign ideal_v = ideal;

    generate
        for (genvar k = 0; k < NGATE; k++) begin : g_dly
            csi_offdly #(.DLY(OFF_DLY), .RST_VAL(ZERO_POS[k])) u_d (
                .clk(clk), .rst(rst), .din(ideal_v[k]), .dout(out_v[k])
            );
        end
    endgenerate

    assign gate_o = out_v;

    // R1: reset forces the zero state
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (gate_o == 8'h3A));

    // R10: each leg always carries its inductor current
    p_path_a_r10: assert property (@(posedge clk) disable iff (rst)
        (gate_o[0] || gate_o[1]));
    p_path_b_r10: assert property (@(posedge clk) disable iff (rst)
        (gate_o[2] || gate_o[3]));

endmodule

// File: tb/csi_gate_seq_tb.sv
`timescale 1ns/1ps
module csi_gate_seq_tb;
    localparam int DW  = 8;
    localparam int DLY = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_stb = 1'b0;
    logic signed [2:0] lvl_req = '0;
    logic single_ind = 1'b0;
    logic signed [DW-1:0] v_load = '0, i_ind1 = '0, i_ind2 = '0, i_src = '0;
    logic [DW-2:0] hyst_band = '0;
    logic [7:0] gate_o;

    int checks = 0;
    int errors = 0;
    bit m_pol = 1;
    bit m_imb = 1;
    bit m_vp  = 1;
    int m_lvl = 0;

    always #5 clk = ~clk;

    csi_gate_seq #(.DW(DW), .OFF_DLY(DLY)) u_dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .lvl_req(lvl_req),
        .single_ind(single_ind), .v_load(v_load), .i_ind1(i_ind1),
        .i_ind2(i_ind2), .i_src(i_src), .hyst_band(hyst_band), .gate_o(gate_o)
    );

    function automatic int expg(int l, bit pol, bit vp, bit ip);
        int s;
        if (l >= 2) return 1 + 4 + 16 + 32;
        if (l <= -2) return 1 + 4 + 64 + 128;
        if (l == 0) return 2 + 8 + (pol ? 48 : 192);
        s = (l > 0 ? 1 : -1) * (vp ? 1 : -1) * (ip ? 1 : -1);
        return ((s > 0) ? 9 : 6) + ((l > 0) ? 48 : 192);
    endfunction

    task automatic chk(input int exp, input string tag);
        checks++;
        if (gate_o !== exp[7:0]) begin
            errors++;
            $display("FAIL %s gate_o=%02h expected=%02h", tag, gate_o, exp[7:0]);
        end
    endtask

    task automatic strobe(input int l, input int v, input int a, input int b,
                          input int s, input bit sgl, input int band);
        int d;
        @(negedge clk);
        lvl_req = l[2:0]; v_load = v[DW-1:0]; i_ind1 = a[DW-1:0];
        i_ind2 = b[DW-1:0]; i_src = s[DW-1:0]; single_ind = sgl;
        hyst_band = band[DW-2:0]; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        m_lvl = l;
        m_vp  = (v >= 0);
        if (l > 0) m_pol = 1; else if (l < 0) m_pol = 0;
        d = a - (sgl ? (s >>> 1) : b);
        if (d >= band) m_imb = 1; else if (d < -band) m_imb = 0;
    endtask

    task automatic settle();
        repeat (DLY + 2) @(negedge clk);
    endtask

    function automatic string tag_of(int l, bit sgl);
        if (l >= 2 || l <= -2) return "R3";
        if (l == 0) return "R4 R5";
        return sgl ? "R7 R6" : "R6";
    endfunction

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int vs[3];
        int ds[5];
        int held;
        vs = '{-5, 0, 7};
        ds = '{-20, -3, 0, 3, 20};

        repeat (3) @(negedge clk);
        chk(8'h3A, "R1 in reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(8'h3A, "R1 after reset");

        // exhaustive sweep, band 0
        for (int sg = 0; sg < 2; sg++)
            for (int l = -4; l <= 3; l++)
                for (int vi = 0; vi < 3; vi++)
                    for (int di = 0; di < 5; di++) begin
                        if (sg == 0)
                            strobe(l, vs[vi], ds[di] + 5, 5, -60, 1'b0, 0);
                        else
                            strobe(l, vs[vi], ds[di] + 10, -50, 21, 1'b1, 0);
                        settle();
                        chk(expg(m_lvl, m_pol, m_vp, m_imb), tag_of(l, sg[0]));
                    end

        // R5: polarity held through zero requests
        strobe(-1, 3, 0, 0, 0, 1'b0, 0); settle();
        strobe(0, 3, 0, 0, 0, 1'b0, 0); settle();
        chk(8'hCA, "R5 negative held at zero");
        strobe(1, 3, 0, 0, 0, 1'b0, 0); settle();
        strobe(0, -3, 0, 0, 0, 1'b0, 0); settle();
        chk(8'h3A, "R5 positive held at zero");

        // R2: no strobe, no effect
        held = gate_o;
        @(negedge clk);
        lvl_req = 3'sd2; v_load = -8'sd9; i_ind1 = 8'sd50;
        repeat (6) @(negedge clk);
        chk(held, "R2 no strobe");

        // R9: overlap on 0 -> +2
        strobe(2, 3, 0, 0, 0, 1'b0, 0);
        @(negedge clk);
        chk(8'h3F, "R9 overlap first clock");
        repeat (DLY - 1) @(negedge clk);
        chk(8'h3F, "R9 overlap last clock");
        @(negedge clk);
        chk(8'h35, "R9 after extension");
        // +2 -> -2: positive bridge lingers
        strobe(-2, 3, 0, 0, 0, 1'b0, 0);
        @(negedge clk);
        chk(8'hF5, "R9 bridge overlap");
        settle();
        chk(8'hC5, "R3 settled negative");

        // R7: floor rounding of halved source current (-3 -> -2)
        strobe(1, 5, -2, 90, -3, 1'b1, 0); settle();
        chk(8'h39, "R7 diff zero is positive");
        strobe(1, 5, -3, 90, -3, 1'b1, 0); settle();
        chk(8'h36, "R7 diff minus one is negative");

        // R8: hysteresis band of 4, level +1, v positive
        strobe(1, 5, 10, 0, 0, 1'b0, 4); settle();
        chk(8'h39, "R8 above band sets");
        strobe(1, 5, 2, 0, 0, 1'b0, 4); settle();
        chk(8'h39, "R8 inside band holds plus");
        strobe(1, 5, -4, 0, 0, 1'b0, 4); settle();
        chk(8'h39, "R8 at lower edge holds");
        strobe(1, 5, -5, 0, 0, 1'b0, 4); settle();
        chk(8'h36, "R8 below band clears");
        strobe(1, 5, 3, 0, 0, 1'b0, 4); settle();
        chk(8'h36, "R8 inside band holds minus");
        strobe(1, 5, 4, 0, 0, 1'b0, 4); settle();
        chk(8'h39, "R8 at upper edge sets");

        // R1: reset again from a non-zero state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(8'h3A, "R1 reapplied");
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule